// File: doc/BRIEF.md
# Power Rail Gating Sequencer

This controller takes a gated compute partition off its supply rail and brings it back, always in the same order. A gate request quiesces the partition in five steps. It holds memory-client traffic with a flush request, isolates the partition outputs with a clamp, puts the partition into reset, stops its clocks, and marks its thermal sensor invalid. Only then does it ask the rail regulator to power down. An ungate request reverses this. The rail comes up first, the clocks and reset are restored, isolation is released, and memory traffic resumes after a flush-done pulse.

Every timed step is separated by a fixed wait of `WAIT_US` microseconds, derived from the `CYC_PER_US` clock-rate parameter. The rail regulator sits behind a request/acknowledge handshake with a failure flag. A failed power-down or power-up ends the sequence with an error. A failed clock enable during power-up rolls the rail back down. The first power-up after controller reset skips the clock-enable step, because the clocks have not been configured yet. A surrounding power manager drives the two request inputs and watches `busy`, `done` and `err`.

Top module: `rail_gate_seq`

## Requirements
- R1: After reset the block reports `rail_up`=0, `busy`=0, `done`=0, `err`=0, `clamp`=1, `part_rst`=1, `tsens_inval`=1, and all clock enables, `flush_req`, `flush_done` and both rail requests at 0.
- R2: A gate request with the rail up proceeds in this order, with consecutive steps W = CYC_PER_US*WAIT_US cycles apart: `flush_req` rises, then `clamp` rises, then `part_rst` rises, then the gate clock and all reference clocks drop. W cycles after the clocks drop, `tsens_inval` rises, and `rail_off_req` rises one cycle later.
- R3: A gate request while the rail is down changes no output except `done`, which pulses for one cycle on the next edge; `err` stays 0.
- R4: If `rail_fail` is high when a power-down acknowledge arrives, `err` goes to 1 and `rail_up` stays 1. Otherwise `rail_up` goes to 0. In both cases `rail_off_req` drops, `busy` drops and `done` pulses on the acknowledge edge.
- R5: An ungate request with the rail down raises `rail_on_req`. On a good acknowledge, `rail_up` goes to 1 and `tsens_inval` to 0. One cycle later the clocks turn on. W cycles after that `part_rst` is asserted. After W more cycles `clamp` clears, and after W more the gate clock drops. One cycle later `part_rst` releases. One cycle after the release, the gate clock returns together with `flush_req`. After W cycles `flush_done` pulses for one cycle and `flush_req` clears, and W cycles after the pulse `done` pulses and `busy` drops.
- R6: On the first power-up after controller reset, the clock-enable step is skipped: the reference clocks stay 0 and `clk_en_fail` is ignored.
- R7: On a later power-up, `clk_en_fail` high in the clock-enable cycle leaves the clocks off and raises `rail_off_req` and `tsens_inval`. The acknowledge then sets `rail_up` to 0, `err` to 1 and pulses `done`.
- R8: A failed power-up acknowledge sets `err` to 1, pulses `done` and drops `busy`. It takes no further step: `rail_up` stays 0, and the clamp, reset and clocks keep their values.
- R9: `part_rst` is released only while the gate clock is off and the clamp is clear, and the gate clock turns back on in the next cycle.
- R10: While `busy` is 1, gate and ungate requests are ignored. `done` is a single-cycle pulse. When both requests arrive together in idle, the gate request wins.
- R11: An ungate request while the rail is already up changes no output except a one-cycle `done` pulse on the next edge, with `err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_req | input | 1 | Request to power the partition down |
| ungate_req | input | 1 | Request to power the partition up |
| rail_ack | input | 1 | Regulator acknowledge for a rail request |
| rail_fail | input | 1 | Failure flag, valid with rail_ack |
| clk_en_fail | input | 1 | Clock enable failure, sampled in the clock-enable cycle |
| rail_up | output | 1 | Rail is powered |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | Last request ended in failure |
| flush_req | output | 1 | Memory-client flush request (level) |
| flush_done | output | 1 | Memory-client flush-done pulse |
| clamp | output | 1 | Isolation clamp, 1 isolates |
| part_rst | output | 1 | Partition reset, 1 asserted |
| gate_clk_en | output | 1 | Gate clock enable |
| ref_clk_en | output | NREF | Reference clock enables |
| tsens_inval | output | 1 | Thermal sensor invalidate |
| rail_on_req | output | 1 | Rail power-up request |
| rail_off_req | output | 1 | Rail power-down request |

## Verification
The bench runs gate and ungate sequences against a behavioural step model and compares every output on every clock, so a wrong order or an off-by-one in any wait shows up as a mismatch. The runs include a first power-up with a clock failure injected, which separates a correct skip from a late clock enable. Later power-ups cover a good path, a failed rail acknowledge and a failed clock enable, which separates a rollback from a plain abort. Gate requests are tried with the rail down, with a failing acknowledge, with a stray ungate pulse while busy, and together with an ungate request. These show that redundant, concurrent and mid-sequence requests are ignored or resolved toward gating.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_DN_W1,
        S_DN_W2,
        S_DN_W3,
        S_DN_W4,
        S_DN_REQ,
        S_DN_ACK,
        S_UP_ACK,
        S_UP_CLK,
        S_UP_W1,
        S_UP_W2,
        S_UP_W3,
        S_UP_REL,
        S_UP_RESTORE,
        S_UP_W4,
        S_UP_W5,
        S_RB_ACK
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       busy;
        logic       done;
        logic       err;
        logic       rail_up;
        logic       first;
        logic       flush_req;
        logic       flush_done;
        logic       clamp;
        logic       part_rst;
        logic       gate_clk;
        logic       ref_clk;
        logic       tsens;
        logic       on_req;
        logic       off_req;
    } seq_regs_t;

endpackage

// File: rtl/rgs_wait_timer.sv
module rgs_wait_timer #(
    parameter int unsigned WAIT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int unsigned CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/rgs_step_fsm.sv
module rgs_step_fsm
    import rgs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gate_req,
    input  logic      ungate_req,
    input  logic      rail_ack,
    input  logic      rail_fail,
    input  logic      clk_en_fail,
    input  logic      tmr_expired,
    output logic      tmr_start,
    output seq_regs_t regs
);
    seq_regs_t d, q;

    always_comb begin
        d            = q;
        d.done       = 1'b0;
        d.flush_done = 1'b0;
        tmr_start    = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (gate_req) begin
                    d.err = 1'b0;
                    if (q.rail_up) begin
                        d.busy      = 1'b1;
                        d.flush_req = 1'b1;
                        tmr_start   = 1'b1;
                        d.st        = S_DN_W1;
                    end else begin
                        d.done = 1'b1;
                    end
                end else if (ungate_req) begin
                    d.err = 1'b0;
                    if (!q.rail_up) begin
                        d.busy   = 1'b1;
                        d.on_req = 1'b1;
                        d.st     = S_UP_ACK;
                    end else begin
                        d.done = 1'b1;
                    end
                end
            end
            S_DN_W1: begin
                if (tmr_expired) begin
                    d.clamp   = 1'b1;
                    tmr_start = 1'b1;
                    d.st      = S_DN_W2;
                end
            end
            S_DN_W2: begin
                if (tmr_expired) begin
                    d.part_rst = 1'b1;
                    tmr_start  = 1'b1;
                    d.st       = S_DN_W3;
                end
            end
            S_DN_W3: begin
                if (tmr_expired) begin
                    d.gate_clk = 1'b0;
                    d.ref_clk  = 1'b0;
                    tmr_start  = 1'b1;
                    d.st       = S_DN_W4;
                end
            end
            S_DN_W4: begin
                if (tmr_expired) begin
                    d.tsens = 1'b1;
                    d.st    = S_DN_REQ;
                end
            end
            S_DN_REQ: begin
                d.off_req = 1'b1;
                d.st      = S_DN_ACK;
            end
            S_DN_ACK: begin
                if (rail_ack) begin
                    d.off_req = 1'b0;
                    d.rail_up = rail_fail;
                    d.err     = rail_fail;
                    d.busy    = 1'b0;
                    d.done    = 1'b1;
                    d.st      = S_IDLE;
                end
            end
            S_UP_ACK: begin
                if (rail_ack) begin
                    d.on_req = 1'b0;
                    if (rail_fail) begin
                        d.err  = 1'b1;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end else begin
                        d.rail_up = 1'b1;
                        d.tsens   = 1'b0;
                        d.st      = S_UP_CLK;
                    end
                end
            end
            S_UP_CLK: begin
                if (q.first) begin
                    d.first   = 1'b0;
                    tmr_start = 1'b1;
                    d.st      = S_UP_W1;
                end else if (clk_en_fail) begin
                    d.off_req = 1'b1;
                    d.tsens   = 1'b1;
                    d.st      = S_RB_ACK;
                end else begin
                    d.gate_clk = 1'b1;
                    d.ref_clk  = 1'b1;
                    tmr_start  = 1'b1;
                    d.st       = S_UP_W1;
                end
            end
            S_UP_W1: begin
                if (tmr_expired) begin
                    d.part_rst = 1'b1;
                    tmr_start  = 1'b1;
                    d.st       = S_UP_W2;
                end
            end
            S_UP_W2: begin
                if (tmr_expired) begin
                    d.clamp   = 1'b0;
                    tmr_start = 1'b1;
                    d.st      = S_UP_W3;
                end
            end
            S_UP_W3: begin
                if (tmr_expired) begin
                    d.gate_clk = 1'b0;
                    d.st       = S_UP_REL;
                end
            end
            S_UP_REL: begin
                d.part_rst = 1'b0;
                d.st       = S_UP_RESTORE;
            end
            S_UP_RESTORE: begin
                d.gate_clk  = 1'b1;
                d.flush_req = 1'b1;
                tmr_start   = 1'b1;
                d.st        = S_UP_W4;
            end
            S_UP_W4: begin
                if (tmr_expired) begin
                    d.flush_req  = 1'b0;
                    d.flush_done = 1'b1;
                    tmr_start    = 1'b1;
                    d.st         = S_UP_W5;
                end
            end
            S_UP_W5: begin
                if (tmr_expired) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_RB_ACK: begin
                if (rail_ack) begin
                    d.off_req = 1'b0;
                    d.rail_up = rail_fail;
                    d.err     = 1'b1;
                    d.busy    = 1'b0;
                    d.done    = 1'b1;
                    d.st      = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st         <= S_IDLE;
            q.busy       <= 1'b0;
            q.done       <= 1'b0;
            q.err        <= 1'b0;
            q.rail_up    <= 1'b0;
            q.first      <= 1'b1;
            q.flush_req  <= 1'b0;
            q.flush_done <= 1'b0;
            q.clamp      <= 1'b1;
            q.part_rst   <= 1'b1;
            q.gate_clk   <= 1'b0;
            q.ref_clk    <= 1'b0;
            q.tsens      <= 1'b1;
            q.on_req     <= 1'b0;
            q.off_req    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign regs = q;

    // R2: isolation only after traffic is held
    p_clamp_after_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.clamp) |-> q.flush_req);

    // R2: reset asserted only on an isolated partition
    p_rst_after_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.part_rst) |-> q.clamp);

    // R2/R7: rail goes down only when partition is fully quiesced
    p_off_quiesced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.off_req |-> (q.clamp && q.part_rst && q.tsens && !q.gate_clk && !q.ref_clk));

    // R5: power-up request only for a down rail within a sequence
    p_on_when_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.on_req |-> (!q.rail_up && q.busy && !q.off_req));

    // R5: flush-done only after isolation and reset are gone
    p_fdone_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.flush_done |-> (!q.part_rst && !q.clamp));

    // R9: reset release with gate clock stopped, clock back next cycle
    p_release_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.part_rst) |-> (!q.gate_clk && !q.clamp));
    p_clock_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.part_rst) |=> q.gate_clk);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

endmodule

// File: rtl/rail_gate_seq.sv
module rail_gate_seq
    import rgs_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 250,
    parameter int unsigned WAIT_US    = 10,
    parameter int unsigned NREF       = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_req,
    input  logic            ungate_req,
    input  logic            rail_ack,
    input  logic            rail_fail,
    input  logic            clk_en_fail,
    output logic            rail_up,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            flush_req,
    output logic            flush_done,
    output logic            clamp,
    output logic            part_rst,
    output logic            gate_clk_en,
    output logic [NREF-1:0] ref_clk_en,
    output logic            tsens_inval,
    output logic            rail_on_req,
    output logic            rail_off_req
);
    localparam int unsigned WAIT_CYC = CYC_PER_US * WAIT_US;

    logic      tmr_start;
    logic      tmr_expired;
    seq_regs_t regs;

    rgs_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    rgs_step_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_req    (gate_req),
        .ungate_req  (ungate_req),
        .rail_ack    (rail_ack),
        .rail_fail   (rail_fail),
        .clk_en_fail (clk_en_fail),
        .tmr_expired (tmr_expired),
        .tmr_start   (tmr_start),
        .regs        (regs)
    );

    for (genvar i = 0; i < NREF; i++) begin : g_ref
        assign ref_clk_en[i] = regs.ref_clk;
    end

    assign rail_up      = regs.rail_up;
    assign busy         = regs.busy;
    assign done         = regs.done;
    assign err          = regs.err;
    assign flush_req    = regs.flush_req;
    assign flush_done   = regs.flush_done;
    assign clamp        = regs.clamp;
    assign part_rst     = regs.part_rst;
    assign gate_clk_en  = regs.gate_clk;
    assign tsens_inval  = regs.tsens;
    assign rail_on_req  = regs.on_req;
    assign rail_off_req = regs.off_req;

endmodule

// File: tb/sim_rail_gate_seq.sv
module sim_rail_gate_seq;
    localparam int CPU  = 2;
    localparam int WUS  = 10;
    localparam int W    = CPU * WUS;
    localparam int NREF = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic gate_req = 0, ungate_req = 0, rail_ack = 0, rail_fail = 0, clk_en_fail = 0;
    logic rail_up, busy, done, err, flush_req, flush_done, clamp, part_rst;
    logic gate_clk_en, tsens_inval, rail_on_req, rail_off_req;
    logic [NREF-1:0] ref_clk_en;

    rail_gate_seq #(.CYC_PER_US(CPU), .WAIT_US(WUS), .NREF(NREF)) u0 (
        .clk(clk), .rst_n(rst_n), .gate_req(gate_req), .ungate_req(ungate_req),
        .rail_ack(rail_ack), .rail_fail(rail_fail), .clk_en_fail(clk_en_fail),
        .rail_up(rail_up), .busy(busy), .done(done), .err(err),
        .flush_req(flush_req), .flush_done(flush_done), .clamp(clamp),
        .part_rst(part_rst), .gate_clk_en(gate_clk_en), .ref_clk_en(ref_clk_en),
        .tsens_inval(tsens_inval), .rail_on_req(rail_on_req), .rail_off_req(rail_off_req)
    );

    // behavioural expectation
    logic e_up = 0, e_busy = 0, e_done = 0, e_err = 0, e_flush = 0, e_fdone = 0;
    logic e_clamp = 1, e_rst = 1, e_gclk = 0, e_ts = 1, e_on = 0, e_off = 0;
    logic [NREF-1:0] e_ref = '0;
    bit   first_m = 1;
    string tag = "R1";
    int total = 0, bad = 0;
    bit cmp_en = 0, finished = 0;

    task automatic chk(string nm, logic [7:0] act, logic [7:0] ex);
        total++;
        if (act !== ex) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, ex, $time);
        end
    endtask

    task automatic cmp_all();
        chk("rail_up", 8'(rail_up), 8'(e_up));
        chk("busy", 8'(busy), 8'(e_busy));
        chk("done", 8'(done), 8'(e_done));
        chk("err", 8'(err), 8'(e_err));
        chk("flush_req", 8'(flush_req), 8'(e_flush));
        chk("flush_done", 8'(flush_done), 8'(e_fdone));
        chk("clamp", 8'(clamp), 8'(e_clamp));
        chk("part_rst", 8'(part_rst), 8'(e_rst));
        chk("gate_clk_en", 8'(gate_clk_en), 8'(e_gclk));
        chk("ref_clk_en", 8'(ref_clk_en), 8'(e_ref));
        chk("tsens_inval", 8'(tsens_inval), 8'(e_ts));
        chk("rail_on_req", 8'(rail_on_req), 8'(e_on));
        chk("rail_off_req", 8'(rail_off_req), 8'(e_off));
    endtask

    always @(negedge clk) if (cmp_en) cmp_all();

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) edge1();
    endtask

    task automatic pulse_done(string t);
        tag = t;
        e_done = 1;
        edge1();
        e_done = 0;
    endtask

    // gate request; both=1 also raises ungate (gate must win), poke=1 pokes ungate while busy
    task automatic run_gate(bit off_fail, int lat, bit poke, bit both);
        tag = both ? "R10" : "R2";
        gate_req = 1;
        ungate_req = both;
        edge1();
        gate_req = 0;
        ungate_req = 0;
        e_err = 0;
        if (!e_up) begin
            tag = "R3";
            e_done = 1;
            edge1();
            e_done = 0;
            edges(3);
            return;
        end
        e_busy = 1;
        e_flush = 1;
        if (poke) begin
            edges(3);
            tag = "R10";
            ungate_req = 1;
            edge1();
            ungate_req = 0;
            edges(W - 4);
            tag = "R2";
        end else begin
            edges(W);
        end
        e_clamp = 1; edges(W);
        e_rst = 1;   edges(W);
        e_gclk = 0; e_ref = '0; edges(W);
        e_ts = 1;    edge1();
        e_off = 1;
        edges(lat);
        rail_ack = 1;
        rail_fail = off_fail;
        edge1();
        rail_ack = 0;
        rail_fail = 0;
        e_off = 0;
        e_busy = 0;
        if (off_fail) begin
            e_err = 1;
            pulse_done("R4");
        end else begin
            e_up = 0;
            pulse_done("R2");
        end
        edges(2);
    endtask

    task automatic run_ungate(bit on_fail, bit cfail, int lat);
        tag = "R5";
        ungate_req = 1;
        edge1();
        ungate_req = 0;
        e_err = 0;
        if (e_up) begin
            tag = "R11";
            e_done = 1;
            edge1();
            e_done = 0;
            edges(3);
            return;
        end
        e_busy = 1;
        e_on = 1;
        edges(lat);
        rail_ack = 1;
        rail_fail = on_fail;
        edge1();
        rail_ack = 0;
        rail_fail = 0;
        e_on = 0;
        if (on_fail) begin
            e_busy = 0;
            e_err = 1;
            pulse_done("R8");
            edges(W + 2);
            return;
        end
        e_up = 1;
        e_ts = 0;
        clk_en_fail = cfail;
        edge1();
        clk_en_fail = 0;
        if (first_m) begin
            tag = "R6";
            first_m = 0;
        end else if (cfail) begin
            tag = "R7";
            e_off = 1;
            e_ts = 1;
            edges(lat);
            rail_ack = 1;
            edge1();
            rail_ack = 0;
            e_off = 0;
            e_up = 0;
            e_busy = 0;
            e_err = 1;
            pulse_done("R7");
            edges(2);
            return;
        end else begin
            e_gclk = 1;
            e_ref = '1;
        end
        edges(W);
        tag = "R5";
        e_rst = 1;   edges(W);
        e_clamp = 0; edges(W);
        tag = "R9";
        e_gclk = 0;  edge1();
        e_rst = 0;   edge1();
        e_gclk = 1;
        e_flush = 1;
        tag = "R5";
        edges(W);
        e_flush = 0;
        e_fdone = 1;
        edge1();
        e_fdone = 0;
        edges(W - 1);
        e_busy = 0;
        pulse_done("R5");
        edges(2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tag = "R1";
        cmp_all();
        rst_n = 1;
        cmp_en = 1;
        edges(2);
        run_gate(0, 2, 0, 0);   // R3: rail down after reset
        run_ungate(0, 1, 3);    // R6: first power-up, clock failure ignored
        run_ungate(0, 0, 1);    // R11: already up
        run_gate(0, 0, 1, 0);   // R2 with R10 poke while busy
        run_ungate(1, 0, 2);    // R8: rail fails to come up
        run_ungate(0, 1, 1);    // R7: clock failure triggers rollback
        run_ungate(0, 0, 4);    // R5: full power-up with clocks
        run_gate(1, 3, 0, 0);   // R4: power-down fails
        run_gate(0, 1, 0, 1);   // R10: both requests, gate wins
        run_gate(0, 0, 0, 0);   // R3: rail down again
        cmp_en = 0;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

endmodule